// File: doc/BRIEF.md
# Sawtooth Carrier Frequency Search Controller

This block drives the carrier search that runs before a carrier-tracking loop closes. It produces a frequency word for a numerically controlled oscillator, beginning at a programmed start frequency. It then moves that word by a programmed increment after each unsuccessful test. At every frequency it sums a detection metric over a programmed number of arm-filter samples. The samples come from the tracking loop's in-phase and quadrature arm filters at the decimated rate, each marked by a valid strobe.

The metric depends on the carrier type. With a residual carrier it is the in-phase sample alone. With a suppressed carrier it is the magnitude of the in-phase sample minus the magnitude of the quadrature sample. When a dwell sum exceeds the programmed threshold, the word freezes and the acquired flag rises. If a programmed number of frequencies have been tried without success, the word returns to the start frequency and the search repeats without end.

All settings and the mode are captured on the start strobe. A fresh strobe restarts the search at any time, including after acquisition.

Top module: `acq_sweeper`

## Requirements
- R1: While reset is held and after its release, before any start strobe, `freq_o` is 0 and `acq_o` is 0.
- R2: A start strobe in cycle n gives `freq_o` equal to `cfg_f_init_i` and `acq_o` low in cycle n+1 from any state. All `cfg_*` inputs and `mode_i` are captured at the strobe, and later changes to them have no effect until the next strobe. A sample presented in the strobe cycle is not counted.
- R3: With `mode_i`=0 (residual carrier) the per-sample metric is the signed two's-complement `smp_i_i`.
- R4: With `mode_i`=1 (suppressed carrier) the per-sample metric is |`smp_i_i`| − |`smp_q_i`|, with both taken as signed two's complement, so −2048 contributes magnitude 2048.
- R5: Each frequency step integrates exactly `cfg_dwell_i` samples that have `smp_vld_i`=1, with a setting of 0 acting as 1. Cycles with `smp_vld_i`=0 are ignored, and the sum starts from zero at every step.
- R6: The dwell test passes only when the signed sum is strictly greater than the signed `cfg_thresh_i`. On a pass, `acq_o` rises in the cycle after the last sample of the dwell, and `freq_o` keeps the value of that step.
- R7: After a failed dwell, `freq_o` becomes the previous word plus the captured signed step, modulo 2^32, in the cycle after the last sample of the dwell.
- R8: After `cfg_nsteps_i` consecutive failed dwells since the start or the last wrap (0 acts as 1), `freq_o` returns to the captured start frequency instead of stepping.
- R9: Once `acq_o` is high it stays high and `freq_o` stays constant until the next start strobe. Samples arriving in that time have no effect.
- R10: A full dwell of 65535 samples at the maximum magnitude (2048) is summed exactly, without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or restart the search; captures all settings |
| mode_i | input | 1 | 0 residual carrier, 1 suppressed carrier |
| smp_vld_i | input | 1 | Arm sample valid strobe |
| smp_i_i | input | SAMP_W | In-phase arm sample, signed |
| smp_q_i | input | SAMP_W | Quadrature arm sample, signed |
| cfg_f_init_i | input | FREQ_W | Start frequency word, signed |
| cfg_f_step_i | input | FREQ_W | Frequency increment per step, signed |
| cfg_dwell_i | input | DWELL_W | Samples per dwell |
| cfg_nsteps_i | input | STEP_W | Frequencies tried before wrapping |
| cfg_thresh_i | input | ACC_W | Detection threshold, signed |
| freq_o | output | FREQ_W | Frequency word to the oscillator |
| acq_o | output | 1 | Carrier acquired |

## Verification
The bench sets the threshold equal to the dwell sum. A design that compares with greater-or-equal would lock one step too early. It uses a negative step across zero and wraps after the exact step count, so an off-by-one step counter would visit one frequency too many or too few. It tries every in-phase and quadrature pair from a set that includes −2048 in both modes. A design with a wrong absolute value or wrong sign handling would flip the lock decision. It also runs a full maximum-length dwell of extreme samples, where a narrow accumulator would wrap and miss the lock. It drops the valid strobe, changes settings mid-search and feeds samples after lock, so a design that counted idle cycles, used live settings or kept integrating would move the frequency at the wrong time.

// File: rtl/acq_sweep_pkg.sv
package acq_sweep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_LOCKED = 2'd2
    } acq_state_e;
endpackage

// File: rtl/acq_metric.sv
// Per-sample detection metric, selected by carrier type.
module acq_metric #(
    parameter int SAMP_W = 12,
    localparam int MET_W = SAMP_W + 1
) (
    input  logic                     mode_i,
    input  logic signed [SAMP_W-1:0] smp_i_i,
    input  logic signed [SAMP_W-1:0] smp_q_i,
    output logic signed [MET_W-1:0]  metric_o
);
    logic signed [MET_W-1:0] i_ext;
    logic signed [MET_W-1:0] q_ext;
    logic signed [MET_W-1:0] i_mag;
    logic signed [MET_W-1:0] q_mag;

    always_comb begin
        i_ext = {smp_i_i[SAMP_W-1], smp_i_i};
        q_ext = {smp_q_i[SAMP_W-1], smp_q_i};
        i_mag = i_ext[MET_W-1] ? -i_ext : i_ext;
        q_mag = q_ext[MET_W-1] ? -q_ext : q_ext;
        if (mode_i) begin
            metric_o = i_mag - q_mag;
        end else begin
            metric_o = i_ext;
        end
    end
endmodule

// File: rtl/acq_dwell.sv
// Dwell integrator: sums the metric over a programmed sample count.
module acq_dwell #(
    parameter int MET_W   = 13,
    parameter int DWELL_W = 16,
    localparam int ACC_W  = MET_W + DWELL_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     en_i,
    input  logic signed [MET_W-1:0]  metric_i,
    input  logic [DWELL_W-1:0]       dwell_i,
    output logic                     last_o,
    output logic signed [ACC_W-1:0]  sum_o
);
    typedef struct packed {
        logic [DWELL_W-1:0]      cnt;
        logic signed [ACC_W-1:0] acc;
    } dwell_t;

    dwell_t d, q;
    logic [DWELL_W-1:0]      lim;
    logic signed [ACC_W-1:0] met_ext;

    always_comb begin
        lim     = (dwell_i == '0) ? DWELL_W'(1) : dwell_i;
        met_ext = {{(ACC_W-MET_W){metric_i[MET_W-1]}}, metric_i};
        sum_o   = q.acc + met_ext;
        last_o  = en_i && (q.cnt == lim - DWELL_W'(1));
        d       = q;
        if (clr_i || last_o) begin
            d.cnt = '0;
            d.acc = '0;
        end else if (en_i) begin
            d.cnt = q.cnt + DWELL_W'(1);
            d.acc = sum_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/acq_stepper.sv
// Sawtooth frequency generator: step, count, wrap to start.
module acq_stepper #(
    parameter int FREQ_W = 32,
    parameter int STEP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic signed [FREQ_W-1:0] load_freq_i,
    input  logic signed [FREQ_W-1:0] wrap_freq_i,
    input  logic signed [FREQ_W-1:0] step_i,
    input  logic [STEP_W-1:0]        nsteps_i,
    input  logic                     adv_i,
    output logic signed [FREQ_W-1:0] freq_o
);
    typedef struct packed {
        logic [STEP_W-1:0]        idx;
        logic signed [FREQ_W-1:0] freq;
    } step_t;

    step_t d, q;
    logic [STEP_W-1:0] lim;

    always_comb begin
        lim = (nsteps_i == '0) ? STEP_W'(1) : nsteps_i;
        d   = q;
        if (load_i) begin
            d.idx  = '0;
            d.freq = load_freq_i;
        end else if (adv_i) begin
            if (q.idx == lim - STEP_W'(1)) begin
                d.idx  = '0;
                d.freq = wrap_freq_i;
            end else begin
                d.idx  = q.idx + STEP_W'(1);
                d.freq = q.freq + step_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign freq_o = q.freq;
endmodule

// File: rtl/acq_sweeper.sv
module acq_sweeper
    import acq_sweep_pkg::*;
#(
    parameter int SAMP_W  = 12,
    parameter int FREQ_W  = 32,
    parameter int DWELL_W = 16,
    parameter int STEP_W  = 16,
    localparam int MET_W  = SAMP_W + 1,
    localparam int ACC_W  = MET_W + DWELL_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     mode_i,
    input  logic                     smp_vld_i,
    input  logic signed [SAMP_W-1:0] smp_i_i,
    input  logic signed [SAMP_W-1:0] smp_q_i,
    input  logic signed [FREQ_W-1:0] cfg_f_init_i,
    input  logic signed [FREQ_W-1:0] cfg_f_step_i,
    input  logic [DWELL_W-1:0]       cfg_dwell_i,
    input  logic [STEP_W-1:0]        cfg_nsteps_i,
    input  logic signed [ACC_W-1:0]  cfg_thresh_i,
    output logic signed [FREQ_W-1:0] freq_o,
    output logic                     acq_o
);
    typedef struct packed {
        acq_state_e               st;
        logic                     mode;
        logic signed [FREQ_W-1:0] f_init;
        logic signed [FREQ_W-1:0] f_step;
        logic [DWELL_W-1:0]       dwell;
        logic [STEP_W-1:0]        nsteps;
        logic signed [ACC_W-1:0]  thr;
    } ctl_t;

    ctl_t d, q;

    logic signed [MET_W-1:0] metric;
    logic signed [ACC_W-1:0] dwell_sum;
    logic                    dwell_last;
    logic                    smp_en;
    logic                    hit;
    logic                    adv;

    acq_metric #(.SAMP_W(SAMP_W)) u_metric (
        .mode_i   (q.mode),
        .smp_i_i  (smp_i_i),
        .smp_q_i  (smp_q_i),
        .metric_o (metric)
    );

    acq_dwell #(.MET_W(MET_W), .DWELL_W(DWELL_W)) u_dwell (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (start_i),
        .en_i     (smp_en),
        .metric_i (metric),
        .dwell_i  (q.dwell),
        .last_o   (dwell_last),
        .sum_o    (dwell_sum)
    );

    acq_stepper #(.FREQ_W(FREQ_W), .STEP_W(STEP_W)) u_stepper (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (start_i),
        .load_freq_i (cfg_f_init_i),
        .wrap_freq_i (q.f_init),
        .step_i      (q.f_step),
        .nsteps_i    (q.nsteps),
        .adv_i       (adv),
        .freq_o      (freq_o)
    );

    always_comb begin
        smp_en = (q.st == ST_SEARCH) && smp_vld_i && !start_i;
        hit    = dwell_last && (dwell_sum > q.thr);
        adv    = dwell_last && !hit;
        d      = q;
        if (start_i) begin
            d.st     = ST_SEARCH;
            d.mode   = mode_i;
            d.f_init = cfg_f_init_i;
            d.f_step = cfg_f_step_i;
            d.dwell  = cfg_dwell_i;
            d.nsteps = cfg_nsteps_i;
            d.thr    = cfg_thresh_i;
        end else if (hit) begin
            d.st = ST_LOCKED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign acq_o = (q.st == ST_LOCKED);
endmodule

// File: rtl/acq_sweeper_chk.sv
module acq_sweeper_chk #(
    parameter int FREQ_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic signed [FREQ_W-1:0] cfg_f_init_i,
    input logic signed [FREQ_W-1:0] freq_o,
    input logic                     acq_o,
    input logic signed [FREQ_W-1:0] step_q,
    input logic signed [FREQ_W-1:0] init_q
);
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (freq_o == $past(cfg_f_init_i)) && !acq_o); // R2

    AST_LOCK_AT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acq_o) |-> $stable(freq_o)); // R6

    AST_STEP_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !acq_o) |=> (freq_o == $past(freq_o)) ||
                                 (freq_o == $past(freq_o) + step_q) ||
                                 (freq_o == init_q)); // R7

    AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_o && !start_i) |=> acq_o && $stable(freq_o)); // R9

    AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acq_o) |-> $past(start_i)); // R9
endmodule

bind acq_sweeper acq_sweeper_chk #(.FREQ_W(FREQ_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cfg_f_init_i (cfg_f_init_i),
    .freq_o       (freq_o),
    .acq_o        (acq_o),
    .step_q       (q.f_step),
    .init_q       (q.f_init)
);

// File: tb/tb_acq_sweeper.sv
module tb_acq_sweeper;
    localparam int CLK_PERIOD = 10;
    localparam int SAMP_W  = 12;
    localparam int FREQ_W  = 32;
    localparam int DWELL_W = 16;
    localparam int STEP_W  = 16;
    localparam int ACC_W   = SAMP_W + 1 + DWELL_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic mode_i = 1'b0;
    logic smp_vld_i = 1'b0;
    logic signed [SAMP_W-1:0] smp_i_i = '0;
    logic signed [SAMP_W-1:0] smp_q_i = '0;
    logic signed [FREQ_W-1:0] cfg_f_init_i = '0;
    logic signed [FREQ_W-1:0] cfg_f_step_i = '0;
    logic [DWELL_W-1:0] cfg_dwell_i = '0;
    logic [STEP_W-1:0] cfg_nsteps_i = '0;
    logic signed [ACC_W-1:0] cfg_thresh_i = '0;
    logic signed [FREQ_W-1:0] freq_o;
    logic acq_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    acq_sweeper #(.SAMP_W(SAMP_W), .FREQ_W(FREQ_W), .DWELL_W(DWELL_W), .STEP_W(STEP_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .smp_vld_i(smp_vld_i), .smp_i_i(smp_i_i), .smp_q_i(smp_q_i),
        .cfg_f_init_i(cfg_f_init_i), .cfg_f_step_i(cfg_f_step_i),
        .cfg_dwell_i(cfg_dwell_i), .cfg_nsteps_i(cfg_nsteps_i),
        .cfg_thresh_i(cfg_thresh_i), .freq_o(freq_o), .acq_o(acq_o)
    );

    int total = 0;
    int bad = 0;

    // reference state, derived from the requirements
    logic [31:0] m_freq = '0;
    bit m_acq = 1'b0;
    bit m_run = 1'b0;
    longint m_acc = 0;
    int m_cnt = 0;
    int m_idx = 0;
    logic [31:0] l_init = '0;
    logic [31:0] l_step = '0;
    int l_dwell = 1;
    int l_n = 1;
    longint l_thr = 0;
    bit l_mode = 1'b0;

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check(input string tag);
        total++;
        if (freq_o !== m_freq || acq_o !== m_acq) begin
            bad++;
            $display("FAIL %s: freq=%h acq=%b expected freq=%h acq=%b",
                     tag, freq_o, acq_o, m_freq, m_acq);
        end
    endtask

    task automatic set_cfg(input int init, input int step, input int dwell,
                           input int n, input longint thr, input bit mode);
        cfg_f_init_i = init;
        cfg_f_step_i = step;
        cfg_dwell_i  = dwell[DWELL_W-1:0];
        cfg_nsteps_i = n[STEP_W-1:0];
        cfg_thresh_i = thr[ACC_W-1:0];
        mode_i       = mode;
    endtask

    task automatic cyc(input bit st, input bit vld, input int iv, input int qv,
                       input string tag);
        int met;
        @(negedge clk);
        start_i   = st;
        smp_vld_i = vld;
        smp_i_i   = iv[SAMP_W-1:0];
        smp_q_i   = qv[SAMP_W-1:0];
        if (st) begin
            l_init  = cfg_f_init_i;
            l_step  = cfg_f_step_i;
            l_dwell = (cfg_dwell_i == 0) ? 1 : int'(cfg_dwell_i);
            l_n     = (cfg_nsteps_i == 0) ? 1 : int'(cfg_nsteps_i);
            l_thr   = longint'($signed(cfg_thresh_i));
            l_mode  = mode_i;
            m_freq  = cfg_f_init_i;
            m_acq   = 1'b0;
            m_run   = 1'b1;
            m_acc   = 0;
            m_cnt   = 0;
            m_idx   = 0;
        end else if (m_run && vld) begin
            met = l_mode ? (iabs(iv) - iabs(qv)) : iv;
            m_acc += met;
            m_cnt++;
            if (m_cnt >= l_dwell) begin
                if (m_acc > l_thr) begin
                    m_acq = 1'b1;
                    m_run = 1'b0;
                end else begin
                    m_acc = 0;
                    m_cnt = 0;
                    m_idx++;
                    if (m_idx >= l_n) begin
                        m_idx  = 0;
                        m_freq = l_init;
                    end else begin
                        m_freq = m_freq + l_step;
                    end
                end
            end
        end
        @(posedge clk);
        #1;
        check(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int vals[10] = '{-2048, -2047, -3, -1, 0, 1, 2, 3, 2046, 2047};
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        cyc(0, 1, 100, 0, "R1 after release");
        cyc(0, 1, 100, 0, "R1 idle");

        // R7/R8: negative step across zero, wrap after 4 steps, gappy valid (R5)
        set_cfg(14, -7, 3, 4, 50, 0);
        cyc(1, 1, 500, 0, "R2 start");
        for (int k = 0; k < 60; k++)
            cyc(0, (k % 3) != 1, 10, 0, "R5/R7/R8 sweep");

        // R6: sum equal to threshold does not lock, one above does
        set_cfg(1000, 16, 2, 8, 20, 0);
        cyc(1, 0, 0, 0, "R2 start");
        cyc(0, 1, 10, 0, "R6 equal");
        cyc(0, 1, 10, 0, "R6 equal");
        cyc(0, 1, 10, 0, "R6 above");
        cyc(0, 1, 11, 0, "R6 above");
        // R9: frozen after lock, settings changes and samples ignored
        set_cfg(77, 3, 1, 1, -100, 1);
        for (int k = 0; k < 10; k++)
            cyc(0, 1, 2047, -5, "R9 hold");

        // R2: settings captured at start, changed mid-search, restart mid-search
        set_cfg(-20, 5, 2, 3, 1000, 0);
        cyc(1, 1, 0, 0, "R2 start");
        set_cfg(999, 999, 1, 1, -1000, 1);
        for (int k = 0; k < 12; k++)
            cyc(0, 1, k - 6, 4, "R2 captured");
        set_cfg(40, -1, 1, 2, 0, 1);
        cyc(1, 1, 9, 0, "R2 restart");
        cyc(0, 1, 1, 1, "R2 restart");
        cyc(0, 1, 3, -2, "R2 restart");

        // R3/R4: single-sample dwells over a grid of I/Q values
        for (int md = 0; md < 2; md++) begin
            for (int a = 0; a < 10; a++) begin
                for (int b = 0; b < 10; b++) begin
                    set_cfg(0, 1, 1, 2, 0, md[0]);
                    cyc(1, 0, 0, 0, "R2 start");
                    cyc(0, 1, vals[a], vals[b], md ? "R4 metric" : "R3 metric");
                end
            end
        end

        // R5/R8: zero dwell and zero step count act as one
        set_cfg(300, 9, 0, 0, 5, 0);
        cyc(1, 0, 0, 0, "R2 start");
        for (int k = 0; k < 6; k++)
            cyc(0, 1, 2, 0, "R5/R8 zero settings");
        cyc(0, 1, 6, 0, "R6 zero settings lock");

        // R6/R10: long residual dwell equal to threshold does not lock
        set_cfg(5, 1, 40000, 2, 64'sd81880000, 0);
        cyc(1, 0, 0, 0, "R2 start");
        for (int k = 0; k < 40000; k++)
            cyc(0, 1, 2047, 0, "R10 residual equal");

        // R10: maximum dwell of maximum magnitude locks exactly
        set_cfg(-8, 2, 65535, 3, 64'sd134215679, 1);
        cyc(1, 0, 0, 0, "R2 start");
        for (int k = 0; k < 65535; k++)
            cyc(0, 1, -2048, 0, "R10 full dwell");
        cyc(0, 1, -2048, 0, "R10 held");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule